// File: doc/BRIEF.md
# Stream-to-Memory Write Responder

This block stands in for the memory side of a streaming accelerator's write path. The accelerator sends one command word per transfer and then a run of 512-bit stream beats. The block checks the command, works out a start line and a line count, and writes each beat into a local RAM with one line per beat. Once the final beat is stored and a programmable number of cycles has passed, it presents a status word.

A second read port lets the surrounding environment inspect what was stored. Only one transfer is in flight at a time. A new command can replace a status word that has been presented but not yet taken, and that status word is then dropped. A one-cycle error pulse reports malformed commands, partial beats and transfers whose length does not match the command.

Top module: `s2m_wr_responder`

## Requirements
- R1: A command is accepted only when kind=1, align=0, endframe=1, realign=1, tag=0 and byte count is non-zero. A handshake on any other command raises `err` for one cycle in the cycle after the handshake, starts no transfer (`s_tready` stays 0), and leaves `req_cnt` unchanged.
- R2: The start line is the start byte address shifted right by 6 (64 bytes per line), so address bits 5..0 are ignored. A command whose start line is above DEPTH-1 is rejected as in R1.
- R3: Each accepted beat is written to the current line, and the line then advances by one. `rd_data` shows line `rd_line` one clock after `rd_line` is applied.
- R4: `s_tready` is 0 whenever no transfer is active: while idle, while waiting out the latency, and while status is pending. A beat offered in those states stores nothing and produces no status.
- R5: A beat whose `s_tkeep` is not all ones raises `err` in the next cycle. The beat is still stored, and the transfer's status then reports okay=0, interr=1.
- R6: A transfer covers 1 + (bytes-1)/64 lines. If `s_tlast` arrives on any other beat count, `err` pulses after that beat and the status reports okay=0, interr=1.
- R7: With latency N in `cfg_wait`, `sts_valid` rises N cycles after the clock edge that takes the `s_tlast` beat. With N=0 it rises after that same edge.
- R8: A clean transfer's status has okay=1, interr=0, slverr=0, decerr=0 and tag=0. The status is held until `sts_ready` takes it.
- R9: `cmd_ready` is 0 while beats are being taken or the latency is running.
- R10: If a valid command is accepted while a status is still pending, that status is discarded: `sts_valid` is 0 in the next cycle and the new transfer starts.
- R11: `req_cnt` counts accepted commands and wraps to 0 after DEPTH-1.
- R12: While `rst_n` is low, `s_tready`, `sts_valid`, `err` and `req_cnt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_saddr | input | 40 | Start byte address |
| cmd_bytes | input | 23 | Byte count |
| cmd_tag | input | 4 | Command tag, must be 0 |
| cmd_align | input | 6 | Alignment field, must be 0 |
| cmd_kind | input | 1 | Transfer kind, must be 1 |
| cmd_endframe | input | 1 | End-of-frame flag, must be 1 |
| cmd_realign | input | 1 | Realign flag, must be 1 |
| s_tvalid | input | 1 | Stream beat valid |
| s_tready | output | 1 | Stream beat accepted |
| s_tdata | input | 512 | Beat payload |
| s_tkeep | input | 64 | Byte enables, all ones expected |
| s_tlast | input | 1 | Final beat of transfer |
| sts_valid | output | 1 | Status word present |
| sts_ready | input | 1 | Status word taken |
| sts_okay | output | 1 | Transfer clean |
| sts_interr | output | 1 | Data or length fault |
| sts_slverr | output | 1 | Slave error, always 0 |
| sts_decerr | output | 1 | Decode error, always 0 |
| sts_tag | output | 4 | Status tag, always 0 |
| cfg_wait | input | 16 | Status latency in cycles |
| rd_line | input | 6 | Inspection read line |
| rd_data | output | 512 | Inspection read data |
| err | output | 1 | One-cycle fault pulse |
| req_cnt | output | 6 | Accepted-command count, wraps at DEPTH |

## Verification
The assertions watch the per-cycle rules on every cycle: an error pulse after a partial beat, status held stable until it is taken, status appearing right after the final beat when the latency is zero, a stale status dropped by a new command, transfers starting only from a command handshake, and the request counter wrapping. The exact latency count for non-zero settings, the line placement of stored data, the rejection of each illegal command field, and the line-count mismatch are shown only by the bench's scenarios. Those scenarios read lines back through the inspection port and time the status against the final beat.

// File: rtl/s2m_pkg.sv
package s2m_pkg;
  localparam int DATA_W = 512;
  localparam int KEEP_W = DATA_W / 8;
  localparam int LB_SH  = $clog2(KEEP_W);
  localparam int ADDR_W = 40;
  localparam int BBT_W  = 23;
  localparam int TAG_W  = 4;
  localparam int DSA_W  = 6;
  localparam int NL_W   = BBT_W - LB_SH + 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_WAIT = 2'd2,
    ST_STS  = 2'd3
  } wr_state_e;
endpackage

// File: rtl/s2m_cmd_check.sv
module s2m_cmd_check
  import s2m_pkg::*;
#(
  parameter  int DEPTH = 64,
  localparam int LW    = $clog2(DEPTH)
) (
  input  logic [ADDR_W-1:0] saddr,
  input  logic [BBT_W-1:0]  nbytes,
  input  logic [TAG_W-1:0]  tag,
  input  logic [DSA_W-1:0]  align,
  input  logic              kind,
  input  logic              endframe,
  input  logic              realign,
  output logic              ok,
  output logic [LW-1:0]     first_line,
  output logic [NL_W-1:0]   n_lines
);
  localparam int FL_W = ADDR_W - LB_SH;

  logic [FL_W-1:0]  line_full;
  logic [BBT_W-1:0] bytes_m1;
  logic             in_range;
  logic             unused_low;

  assign line_full  = saddr[ADDR_W-1:LB_SH];
  assign in_range   = (line_full <= FL_W'(DEPTH - 1));
  assign first_line = line_full[LW-1:0];
  assign bytes_m1   = nbytes - BBT_W'(1);
  assign n_lines    = {1'b0, bytes_m1[BBT_W-1:LB_SH]} + NL_W'(1);
  assign unused_low = ^{saddr[LB_SH-1:0], bytes_m1[LB_SH-1:0]};

  assign ok = kind && endframe && realign && (align == '0) && (tag == '0) &&
              (nbytes != '0) && in_range;
endmodule

// File: rtl/s2m_line_ram.sv
module s2m_line_ram #(
  parameter  int DEPTH = 64,
  parameter  int DW    = 512,
  localparam int LW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [LW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [LW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/s2m_sts_timer.sv
module s2m_sts_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          start,
  input  logic [CW-1:0] cfg_wait,
  output logic          fire
);
  logic          armed_q, armed_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign fire = (start && (cfg_wait == '0)) || (armed_q && (cnt_q >= cfg_wait));

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    if (clear) begin
      armed_d = 1'b0;
      cnt_d   = '0;
    end else if (start) begin
      armed_d = (cfg_wait != '0);
      cnt_d   = CW'(1);
    end else if (armed_q) begin
      if (cnt_q >= cfg_wait) begin
        armed_d = 1'b0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/s2m_wr_responder.sv
module s2m_wr_responder
  import s2m_pkg::*;
#(
  parameter  int DEPTH  = 64,
  parameter  int WAIT_W = 16,
  localparam int LW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_saddr,
  input  logic [BBT_W-1:0]  cmd_bytes,
  input  logic [TAG_W-1:0]  cmd_tag,
  input  logic [DSA_W-1:0]  cmd_align,
  input  logic              cmd_kind,
  input  logic              cmd_endframe,
  input  logic              cmd_realign,
  input  logic              s_tvalid,
  output logic              s_tready,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic [KEEP_W-1:0] s_tkeep,
  input  logic              s_tlast,
  output logic              sts_valid,
  input  logic              sts_ready,
  output logic              sts_okay,
  output logic              sts_interr,
  output logic              sts_slverr,
  output logic              sts_decerr,
  output logic [TAG_W-1:0]  sts_tag,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic [LW-1:0]     rd_line,
  output logic [DATA_W-1:0] rd_data,
  output logic              err,
  output logic [LW-1:0]     req_cnt
);
  wr_state_e       st_q, st_d;
  logic [LW-1:0]   line_q, line_d;
  logic [NL_W-1:0] beat_q, beat_d;
  logic [NL_W-1:0] nlines_q, nlines_d;
  logic            xerr_q, xerr_d;
  logic            err_q, err_d;
  logic [LW-1:0]   req_q, req_d;

  logic            cmd_ok;
  logic [LW-1:0]   cmd_first;
  logic [NL_W-1:0] cmd_lines;
  logic            cmd_hs, cmd_go, cmd_bad;
  logic            beat_hs, last_hs, keep_bad, len_bad;
  logic            sts_hs, fire;

  s2m_cmd_check #(.DEPTH(DEPTH)) u_check (
    .saddr      (cmd_saddr),
    .nbytes     (cmd_bytes),
    .tag        (cmd_tag),
    .align      (cmd_align),
    .kind       (cmd_kind),
    .endframe   (cmd_endframe),
    .realign    (cmd_realign),
    .ok         (cmd_ok),
    .first_line (cmd_first),
    .n_lines    (cmd_lines)
  );

  s2m_line_ram #(.DEPTH(DEPTH), .DW(DATA_W)) u_ram (
    .clk   (clk),
    .we    (beat_hs),
    .waddr (line_q),
    .wdata (s_tdata),
    .raddr (rd_line),
    .rdata (rd_data)
  );

  s2m_sts_timer #(.CW(WAIT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (cmd_go),
    .start    (last_hs),
    .cfg_wait (cfg_wait),
    .fire     (fire)
  );

  assign cmd_ready = (st_q == ST_IDLE) || (st_q == ST_STS);
  assign cmd_hs    = cmd_valid && cmd_ready;
  assign cmd_go    = cmd_hs && cmd_ok;
  assign cmd_bad   = cmd_hs && !cmd_ok;
  assign s_tready  = (st_q == ST_DATA);
  assign beat_hs   = s_tvalid && s_tready;
  assign last_hs   = beat_hs && s_tlast;
  assign keep_bad  = beat_hs && (s_tkeep != '1);
  assign len_bad   = last_hs && ((beat_q + NL_W'(1)) != nlines_q);
  assign sts_valid = (st_q == ST_STS);
  assign sts_hs    = sts_valid && sts_ready;

  assign sts_okay   = !xerr_q;
  assign sts_interr = xerr_q;
  assign sts_slverr = 1'b0;
  assign sts_decerr = 1'b0;
  assign sts_tag    = '0;
  assign err        = err_q;
  assign req_cnt    = req_q;

  always_comb begin
    st_d     = st_q;
    line_d   = line_q;
    beat_d   = beat_q;
    nlines_d = nlines_q;
    xerr_d   = xerr_q;
    req_d    = req_q;
    err_d    = cmd_bad || keep_bad || len_bad;
    case (st_q)
      ST_IDLE: if (cmd_go) st_d = ST_DATA;
      ST_DATA: if (last_hs) st_d = fire ? ST_STS : ST_WAIT;
      ST_WAIT: if (fire) st_d = ST_STS;
      ST_STS: begin
        if (cmd_go)      st_d = ST_DATA;
        else if (sts_hs) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
    if (cmd_go) begin
      line_d   = cmd_first;
      beat_d   = '0;
      nlines_d = cmd_lines;
      xerr_d   = 1'b0;
      req_d    = (req_q == LW'(DEPTH - 1)) ? '0 : req_q + LW'(1);
    end else if (beat_hs) begin
      line_d = line_q + LW'(1);
      beat_d = beat_q + NL_W'(1);
      if (keep_bad || len_bad) xerr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      line_q   <= '0;
      beat_q   <= '0;
      nlines_q <= '0;
      xerr_q   <= 1'b0;
      err_q    <= 1'b0;
      req_q    <= '0;
    end else begin
      st_q     <= st_d;
      line_q   <= line_d;
      beat_q   <= beat_d;
      nlines_q <= nlines_d;
      xerr_q   <= xerr_d;
      err_q    <= err_d;
      req_q    <= req_d;
    end
  end

  AST_START_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_tready) |-> $past(cmd_valid)); // R1
  AST_PARTIAL_BEAT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tvalid && s_tready && (s_tkeep != '1)) |=> err); // R5
  AST_ZERO_WAIT_STS: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tvalid && s_tready && s_tlast && (cfg_wait == '0)) |=> sts_valid); // R7
  AST_STS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_valid && !sts_ready && !cmd_valid) |=> (sts_valid && $stable(sts_okay))); // R8
  AST_STALE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_valid && cmd_go) |=> (!sts_valid && s_tready)); // R10
  AST_REQ_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && (req_cnt == LW'(DEPTH - 1))) |=> (req_cnt == '0)); // R11
endmodule

// File: tb/s2m_wr_responder_tb_top.sv
`timescale 1ns/1ps
module s2m_wr_responder_tb_top;
  localparam int DEPTH = 64;
  localparam int LW    = $clog2(DEPTH);

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cmd_valid, cmd_ready;
  logic [39:0]  cmd_saddr;
  logic [22:0]  cmd_bytes;
  logic [3:0]   cmd_tag;
  logic [5:0]   cmd_align;
  logic         cmd_kind, cmd_endframe, cmd_realign;
  logic         s_tvalid, s_tready, s_tlast;
  logic [511:0] s_tdata;
  logic [63:0]  s_tkeep;
  logic         sts_valid, sts_ready, sts_okay, sts_interr, sts_slverr, sts_decerr;
  logic [3:0]   sts_tag;
  logic [15:0]  cfg_wait;
  logic [LW-1:0] rd_line, req_cnt;
  logic [511:0] rd_data;
  logic         err;

  int n_chk = 0;
  int n_err = 0;
  int acc_total = 0;

  always #5 clk = ~clk;

  s2m_wr_responder #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_saddr(cmd_saddr),
    .cmd_bytes(cmd_bytes), .cmd_tag(cmd_tag), .cmd_align(cmd_align),
    .cmd_kind(cmd_kind), .cmd_endframe(cmd_endframe), .cmd_realign(cmd_realign),
    .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata),
    .s_tkeep(s_tkeep), .s_tlast(s_tlast),
    .sts_valid(sts_valid), .sts_ready(sts_ready), .sts_okay(sts_okay),
    .sts_interr(sts_interr), .sts_slverr(sts_slverr), .sts_decerr(sts_decerr),
    .sts_tag(sts_tag), .cfg_wait(cfg_wait), .rd_line(rd_line),
    .rd_data(rd_data), .err(err), .req_cnt(req_cnt)
  );

  typedef struct packed {
    logic [39:0] saddr;
    logic [22:0] nbytes;
    logic [3:0]  tag;
    logic [5:0]  align;
    logic        kind;
    logic        endf;
    logic        realn;
    logic [7:0]  wt;
    logic        acc;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{40'd0,    23'd64,  4'd0, 6'd0, 1'b1, 1'b1, 1'b1, 8'd0, 1'b1},
    '{40'd128,  23'd130, 4'd0, 6'd0, 1'b1, 1'b1, 1'b1, 8'd3, 1'b1},
    '{40'd640,  23'd1,   4'd0, 6'd0, 1'b1, 1'b1, 1'b1, 8'd1, 1'b1},
    '{40'd0,    23'd64,  4'd0, 6'd0, 1'b0, 1'b1, 1'b1, 8'd0, 1'b0},
    '{40'd0,    23'd64,  4'd5, 6'd0, 1'b1, 1'b1, 1'b1, 8'd0, 1'b0},
    '{40'd4096, 23'd64,  4'd0, 6'd0, 1'b1, 1'b1, 1'b1, 8'd0, 1'b0},
    '{40'd0,    23'd64,  4'd0, 6'd1, 1'b1, 1'b1, 1'b1, 8'd0, 1'b0},
    '{40'd3845, 23'd256, 4'd0, 6'd0, 1'b1, 1'b1, 1'b1, 8'd7, 1'b1},
    '{40'd0,    23'd64,  4'd0, 6'd0, 1'b1, 1'b0, 1'b1, 8'd0, 1'b0},
    '{40'd0,    23'd64,  4'd0, 6'd0, 1'b1, 1'b1, 1'b0, 8'd0, 1'b0},
    '{40'd0,    23'd0,   4'd0, 6'd0, 1'b1, 1'b1, 1'b1, 8'd0, 1'b0}
  };

  function automatic logic [511:0] pat(input int v);
    return {16{32'hA500_0000 ^ 32'(v)}};
  endfunction

  task automatic chk(input bit cond, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!cond) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic chkeq(input string rq, input logic [63:0] act, input logic [63:0] exp);
    chk(act == exp, rq, act, exp);
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic send_cmd(input logic [39:0] sa, input logic [22:0] nb, input logic [3:0] tg,
                          input logic [5:0] al, input logic kd, input logic ef, input logic rl,
                          input bit acc, input string rq);
    chkeq(rq, 64'(cmd_ready), 64'd1);
    cmd_saddr = sa; cmd_bytes = nb; cmd_tag = tg; cmd_align = al;
    cmd_kind = kd; cmd_endframe = ef; cmd_realign = rl; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chkeq(rq, 64'(err), 64'(!acc));
    chkeq(rq, 64'(s_tready), 64'(acc));
    if (acc) begin
      acc_total++;
      chkeq("R9", 64'(cmd_ready), 64'd0);
    end
    chkeq("R11", 64'(req_cnt), 64'(acc_total % DEPTH));
  endtask

  task automatic send_beats(input int n, input int lines, input int seed, input int bad_idx);
    for (int b = 0; b < n; b++) begin
      chkeq("R3", 64'(s_tready), 64'd1);
      s_tvalid = 1'b1;
      s_tdata  = pat(seed + b);
      s_tkeep  = (b == bad_idx) ? 64'h7FFF_FFFF_FFFF_FFFF : '1;
      s_tlast  = (b == n - 1);
      @(negedge clk);
      chkeq((b == bad_idx) ? "R5" : "R6", 64'(err),
            64'((b == bad_idx) || ((b == n - 1) && (n != lines))));
    end
    s_tvalid = 1'b0;
    s_tlast  = 1'b0;
    s_tkeep  = '1;
  endtask

  task automatic wait_sts(input int n_exp);
    int k = 0;
    while (!sts_valid && k < 300) begin
      @(negedge clk);
      k++;
    end
    chkeq("R7", 64'(k), 64'(n_exp));
  endtask

  task automatic take_sts(input bit bad);
    chkeq("R8", 64'(sts_valid), 64'd1);
    chkeq(bad ? "R5" : "R8", 64'({sts_okay, sts_interr}), bad ? 64'b01 : 64'b10);
    chkeq("R8", 64'({sts_slverr, sts_decerr, sts_tag}), 64'd0);
    repeat (2) @(negedge clk);
    chkeq("R8", 64'(sts_valid), 64'd1);
    sts_ready = 1'b1;
    @(negedge clk);
    sts_ready = 1'b0;
    chkeq("R8", 64'(sts_valid), 64'd0);
  endtask

  task automatic read_line(input int ln, input logic [511:0] exp, input string rq);
    rd_line = LW'(ln);
    @(negedge clk);
    chk(rd_data == exp, rq, rd_data[63:0], exp[63:0]);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog R1..: run did not complete, actual hung expected done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    cmd_valid = 1'b0; cmd_saddr = '0; cmd_bytes = '0; cmd_tag = '0; cmd_align = '0;
    cmd_kind = 1'b0; cmd_endframe = 1'b0; cmd_realign = 1'b0;
    s_tvalid = 1'b0; s_tdata = '0; s_tkeep = '1; s_tlast = 1'b0;
    sts_ready = 1'b0; cfg_wait = '0; rd_line = '0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chkeq("R12", 64'({s_tready, sts_valid, err}), 64'd0);
    chkeq("R12", 64'(req_cnt), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table of commands walked by one loop (R1, R2, R3, R7, R8)
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      int lines;
      v = VEC[i];
      cfg_wait = 16'(v.wt);
      send_cmd(v.saddr, v.nbytes, v.tag, v.align, v.kind, v.endf, v.realn, v.acc,
               (v.saddr >= 40'd4096) ? "R2" : "R1");
      if (v.acc) begin
        lines = 1 + (int'(v.nbytes) - 1) / 64;
        send_beats(lines, lines, i * 16, -1);
        wait_sts(int'(v.wt));
        take_sts(1'b0);
        for (int b = 0; b < lines; b++)
          read_line(int'(v.saddr >> 6) + b, pat(i * 16 + b), "R3");
      end else begin
        repeat (2) @(negedge clk);
        chkeq("R1", 64'({s_tready, sts_valid}), 64'd0);
      end
    end

    // R4: beat offered while idle is refused and not stored
    s_tvalid = 1'b1; s_tlast = 1'b1; s_tdata = pat(999);
    chkeq("R4", 64'(s_tready), 64'd0);
    @(negedge clk);
    chkeq("R4", 64'({sts_valid, err}), 64'd0);
    s_tvalid = 1'b0; s_tlast = 1'b0;
    read_line(0, pat(0), "R4");

    // R5: partial beat still stored, status reports fault
    cfg_wait = 16'd2;
    send_cmd(40'd1280, 23'd128, 4'd0, 6'd0, 1'b1, 1'b1, 1'b1, 1'b1, "R5");
    send_beats(2, 2, 500, 0);
    wait_sts(2);
    take_sts(1'b1);
    read_line(20, pat(500), "R5");

    // R6: tlast on the wrong beat count
    cfg_wait = 16'd0;
    send_cmd(40'd1920, 23'd192, 4'd0, 6'd0, 1'b1, 1'b1, 1'b1, 1'b1, "R6");
    send_beats(2, 3, 600, -1);
    wait_sts(0);
    take_sts(1'b1);

    // R10: pending status replaced by a new command
    send_cmd(40'd2560, 23'd64, 4'd0, 6'd0, 1'b1, 1'b1, 1'b1, 1'b1, "R10");
    send_beats(1, 1, 700, -1);
    wait_sts(0);
    send_cmd(40'd2624, 23'd64, 4'd0, 6'd0, 1'b1, 1'b1, 1'b1, 1'b1, "R10");
    chkeq("R10", 64'(sts_valid), 64'd0);
    send_beats(1, 1, 710, -1);
    wait_sts(0);
    take_sts(1'b0);
    read_line(41, pat(710), "R10");

    // R11: request counter wraps at DEPTH
    for (int j = 0; j < DEPTH; j++) begin
      send_cmd(40'd3200, 23'd64, 4'd0, 6'd0, 1'b1, 1'b1, 1'b1, 1'b1, "R11");
      send_beats(1, 1, 800 + j, -1);
      wait_sts(0);
      sts_ready = 1'b1;
      @(negedge clk);
      sts_ready = 1'b0;
    end
    read_line(50, pat(800 + DEPTH - 1), "R3");

    finish_run();
  end
endmodule